// File: doc/BRIEF.md
# Programmable Two-Divider Phase-Frequency Comparator

This block is the digital heart of a frequency synthesizer loop. It runs on one system clock and takes two tick strobes. `ref_tick` pulses once for each cycle of the crystal reference and `osc_tick` once for each cycle of the tuned oscillator. Each strobe feeds its own 16-bit programmable divider. The two divided edges go to a tri-state phase-frequency comparator, which drives pump-up and pump-down requests for an external charge pump. A two-bit current level leaves the block next to those requests.

A small write-only register port sets four things: both division ratios, the pump current level and the number of quiet comparisons needed before the lock flag rises. A new ratio is parked until the divider reaches its terminal count, so the interval that is running is never cut short.

Top module: `pll_core`

## Requirements
- R1: The reference divider raises `ref_edge` for exactly one cycle after every N accepted `ref_tick` strobes. N is the value written at `cfg_addr` 0.
- R2: The oscillator divider raises `osc_edge` for exactly one cycle after every M accepted `osc_tick` strobes. M is the value written at `cfg_addr` 1.
- R3: A written ratio of 0 or 1 is treated as 2, so no divider ever produces edges in two consecutive cycles.
- R4: A newly written ratio is used only from the next terminal count on. The interval in progress keeps its old length.
- R5: `pump_up` sets in the cycle after a `ref_edge`, and `pump_dn` sets in the cycle after an `osc_edge`. When both would be set, both clear. The two are never high together, and coincident edges leave both low.
- R6: Writing `cfg_addr` 2 loads `cfg_wdata[1:0]` onto `pump_isel` in the next cycle. The levels are 0 = 25 uA, 1 = 100 uA, 2 = 500 uA and 3 = 2 mA.
- R7: `locked` rises after T consecutive reference comparisons in which neither pump request stayed high across more than one `ref_tick`. T is the value written at `cfg_addr` 3 (low 8 bits, 0 read as 1). A comparison that fails this test clears the count, and `locked` then falls.
- R8: While `rst` is high, all outputs are held low and `pump_isel` is 0. Both ratios reset to 4 and T resets to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One strobe per reference cycle |
| osc_tick | input | 1 | One strobe per oscillator cycle |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select: 0 ref ratio, 1 osc ratio, 2 current level, 3 lock count |
| cfg_wdata | input | 16 | Register write data |
| ref_edge | output | 1 | Divided reference edge |
| osc_edge | output | 1 | Divided oscillator edge |
| pump_up | output | 1 | Charge-pump up request |
| pump_dn | output | 1 | Charge-pump down request |
| pump_isel | output | 2 | Charge-pump current level |
| locked | output | 1 | Lock indicator |

## Verification
Equal ratios with strobes on every cycle keep the divided edges coincident. This separates a correct tri-state comparator, which stays silent, from one that leaves a request hanging, and it shows the lock count climbing to its threshold. A ratio mismatch then holds the up request open across many reference ticks, which must clear the lock. Sparse random strobes mixed with random rewrites of the ratios, including 0 and 1, expose any divider that reloads early, drops a tick or cuts the running interval. A per-cycle model of the comparator catches a missing or stuck request.

// File: rtl/pll_pkg.sv
package pll_pkg;
  typedef enum logic [1:0] {
    REG_REF_DIV  = 2'd0,
    REG_OSC_DIV  = 2'd1,
    REG_PUMP_LVL = 2'd2,
    REG_LOCK_CNT = 2'd3
  } cfg_reg_e;

  localparam int MIN_RATIO = 2;
endpackage

// File: rtl/pll_cfg.sv
module pll_cfg
  import pll_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int LOCK_W   = 8,
  parameter int REF_RST  = 4,
  parameter int MAIN_RST = 4,
  parameter int LOCK_RST = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [DIV_W-1:0]  wdata,
  output logic [DIV_W-1:0]  ref_n,
  output logic [DIV_W-1:0]  osc_n,
  output logic [1:0]        isel,
  output logic [LOCK_W-1:0] lock_thr
);
  localparam logic [DIV_W-1:0] MIN_C = DIV_W'(MIN_RATIO);
  localparam logic [DIV_W-1:0] REF_C = (REF_RST < MIN_RATIO) ? MIN_C : DIV_W'(REF_RST);
  localparam logic [DIV_W-1:0] OSC_C = (MAIN_RST < MIN_RATIO) ? MIN_C : DIV_W'(MAIN_RST);

  function automatic logic [DIV_W-1:0] clamp_ratio(input logic [DIV_W-1:0] v);
    return (v < MIN_C) ? MIN_C : v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_n    <= REF_C;
      osc_n    <= OSC_C;
      isel     <= 2'd0;
      lock_thr <= LOCK_W'(LOCK_RST);
    end else if (we) begin
      case (cfg_reg_e'(addr))
        REG_REF_DIV:  ref_n    <= clamp_ratio(wdata);
        REG_OSC_DIV:  osc_n    <= clamp_ratio(wdata);
        REG_PUMP_LVL: isel     <= wdata[1:0];
        REG_LOCK_CNT: lock_thr <= wdata[LOCK_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pll_div.sv
module pll_div #(
  parameter int W     = 16,
  parameter int RST_N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] load_n,
  output logic         pulse
);
  localparam logic [W-1:0] RST_C = (RST_N < 2) ? W'(2) : W'(RST_N);

  logic [W-1:0] cnt;
  logic         term;

  assign term = (cnt <= W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= RST_C;
      pulse <= 1'b0;
    end else begin
      pulse <= tick && term;
      if (tick) begin
        if (term) cnt <= load_n;
        else      cnt <= cnt - W'(1);
      end
    end
  end
endmodule

// File: rtl/pll_pfd.sv
module pll_pfd (
  input  logic clk,
  input  logic rst,
  input  logic ref_ev,
  input  logic osc_ev,
  output logic up,
  output logic dn
);
  logic up_nx, dn_nx;

  always_comb begin
    up_nx = up | ref_ev;
    dn_nx = dn | osc_ev;
    if (up_nx && dn_nx) begin
      up_nx = 1'b0;
      dn_nx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up_nx;
      dn <= dn_nx;
    end
  end
endmodule

// File: rtl/pll_lock.sv
module pll_lock #(
  parameter int LOCK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              ref_ev,
  input  logic              up,
  input  logic              dn,
  input  logic [LOCK_W-1:0] thr,
  output logic              locked
);
  logic              act, long_now, wide;
  logic [1:0]        hi_cnt;
  logic [LOCK_W-1:0] good, eff_thr;

  assign act      = up | dn;
  assign long_now = act && ref_tick && (hi_cnt != 2'd0);
  assign eff_thr  = (thr == '0) ? LOCK_W'(1) : thr;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= 2'd0;
      wide   <= 1'b0;
      good   <= '0;
      locked <= 1'b0;
    end else begin
      if (!act)                           hi_cnt <= 2'd0;
      else if (ref_tick && hi_cnt != 2'd2) hi_cnt <= hi_cnt + 2'd1;

      if (ref_ev)        wide <= 1'b0;
      else if (long_now) wide <= 1'b1;

      if (ref_ev) begin
        if (wide || long_now) good <= '0;
        else if (good != '1)  good <= good + LOCK_W'(1);
      end

      locked <= (good >= eff_thr);
    end
  end
endmodule

// File: rtl/pll_core.sv
module pll_core
  import pll_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int LOCK_W   = 8,
  parameter int REF_RST  = 4,
  parameter int MAIN_RST = 4,
  parameter int LOCK_RST = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             osc_tick,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [DIV_W-1:0] cfg_wdata,
  output logic             ref_edge,
  output logic             osc_edge,
  output logic             pump_up,
  output logic             pump_dn,
  output logic [1:0]       pump_isel,
  output logic             locked
);
  localparam int NDIV = 2;

  logic [DIV_W-1:0]  ratio [NDIV];
  logic [NDIV-1:0]   tick_v, edge_v;
  logic [LOCK_W-1:0] lock_thr;

  assign tick_v = {osc_tick, ref_tick};

  pll_cfg #(
    .DIV_W(DIV_W), .LOCK_W(LOCK_W), .REF_RST(REF_RST),
    .MAIN_RST(MAIN_RST), .LOCK_RST(LOCK_RST)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .ref_n(ratio[0]), .osc_n(ratio[1]), .isel(pump_isel), .lock_thr(lock_thr)
  );

  for (genvar i = 0; i < NDIV; i++) begin : g_div
    pll_div #(
      .W(DIV_W), .RST_N((i == 0) ? REF_RST : MAIN_RST)
    ) u_div (
      .clk(clk), .rst(rst), .tick(tick_v[i]), .load_n(ratio[i]), .pulse(edge_v[i])
    );
  end

  assign ref_edge = edge_v[0];
  assign osc_edge = edge_v[1];

  pll_pfd u_pfd (
    .clk(clk), .rst(rst), .ref_ev(edge_v[0]), .osc_ev(edge_v[1]),
    .up(pump_up), .dn(pump_dn)
  );

  pll_lock #(.LOCK_W(LOCK_W)) u_lock (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .ref_ev(edge_v[0]),
    .up(pump_up), .dn(pump_dn), .thr(lock_thr), .locked(locked)
  );
endmodule

// File: rtl/pll_core_chk.sv
module pll_core_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_we,
  input logic [1:0] cfg_addr,
  input logic [1:0] wd_lo,
  input logic       ref_edge,
  input logic       osc_edge,
  input logic       pump_up,
  input logic       pump_dn,
  input logic [1:0] pump_isel,
  input logic       locked
);
  assert_no_both_R5: assert property (@(posedge clk) disable iff (rst)
    !(pump_up && pump_dn));
  assert_up_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pump_up) |-> $past(ref_edge));
  assert_dn_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(pump_dn) |-> $past(osc_edge));
  assert_ref_gap_R3: assert property (@(posedge clk) disable iff (rst)
    ref_edge |=> !ref_edge);
  assert_osc_gap_R3: assert property (@(posedge clk) disable iff (rst)
    osc_edge |=> !osc_edge);
  assert_isel_load_R6: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 2'd2) |=> (pump_isel == $past(wd_lo)));
  assert_lock_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(ref_edge, 2));
endmodule

bind pll_core pll_core_chk u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .wd_lo(cfg_wdata[1:0]),
  .ref_edge(ref_edge), .osc_edge(osc_edge), .pump_up(pump_up), .pump_dn(pump_dn),
  .pump_isel(pump_isel), .locked(locked)
);

// File: tb/pll_core_tb.sv
`timescale 1ns/1ps
module pll_core_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b0, osc_tick = 1'b0, cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic ref_edge, osc_edge, pump_up, pump_dn, locked;
  logic [1:0] pump_isel;

  always #2.5 clk = ~clk;

  pll_core u_dut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .osc_tick(osc_tick),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .ref_edge(ref_edge), .osc_edge(osc_edge), .pump_up(pump_up),
    .pump_dn(pump_dn), .pump_isel(pump_isel), .locked(locked)
  );

  int nchk = 0, nfail = 0;
  bit chk_en = 0;
  logic p_rt, p_ot, p_we;
  logic [1:0] p_a;
  logic [15:0] p_d;
  int ref_acc, osc_acc, ref_cur, ref_pend, osc_cur, osc_pend;
  logic e_up, e_dn;
  logic [1:0] e_isel;

  function automatic int clampv(input int v);
    return (v < 2) ? 2 : v;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic model_reset();
    ref_acc = 0; osc_acc = 0;
    ref_cur = 4; ref_pend = 4; osc_cur = 4; osc_pend = 4;
    e_up = 0; e_dn = 0; e_isel = 2'd0;
    p_rt = 0; p_ot = 0; p_we = 0; p_a = 0; p_d = 0;
  endtask

  task automatic step(input logic rt, input logic ot, input logic we,
                      input logic [1:0] a, input logic [15:0] d);
    logic nu, nd;
    @(negedge clk);
    if (chk_en) begin
      ref_acc += int'(p_rt);
      osc_acc += int'(p_ot);
      if (ref_edge) begin
        check(ref_acc == ref_cur, "R1/R4", "ref interval", ref_acc, ref_cur);
        ref_acc = 0; ref_cur = ref_pend;
      end else if (ref_acc >= ref_cur)
        check(0, "R1", "ref edge missing, ticks", ref_acc, ref_cur);
      if (osc_edge) begin
        check(osc_acc == osc_cur, "R2/R4", "osc interval", osc_acc, osc_cur);
        osc_acc = 0; osc_cur = osc_pend;
      end else if (osc_acc >= osc_cur)
        check(0, "R2", "osc edge missing, ticks", osc_acc, osc_cur);
      check(pump_up == e_up, "R5", "pump_up", int'(pump_up), int'(e_up));
      check(pump_dn == e_dn, "R5", "pump_dn", int'(pump_dn), int'(e_dn));
      nu = e_up | ref_edge; nd = e_dn | osc_edge;
      if (nu && nd) begin nu = 0; nd = 0; end
      e_up = nu; e_dn = nd;
      if (p_we) begin
        case (p_a)
          2'd0: ref_pend = clampv(int'(p_d));
          2'd1: osc_pend = clampv(int'(p_d));
          2'd2: e_isel = p_d[1:0];
          default: ;
        endcase
      end
      check(pump_isel == e_isel, "R6", "pump_isel", int'(pump_isel), int'(e_isel));
    end
    ref_tick = rt; osc_tick = ot; cfg_we = we; cfg_addr = a; cfg_wdata = d;
    p_rt = rt; p_ot = ot; p_we = we; p_a = a; p_d = d;
  endtask

  task automatic do_reset();
    chk_en = 0;
    @(negedge clk);
    rst = 1; ref_tick = 0; osc_tick = 0; cfg_we = 0;
    repeat (3) @(negedge clk);
    check(!ref_edge && !osc_edge && !pump_up && !pump_dn && !locked, "R8",
          "outputs in reset", int'({ref_edge, osc_edge, pump_up, pump_dn, locked}), 0);
    check(pump_isel == 2'd0, "R8", "pump_isel in reset", int'(pump_isel), 0);
    rst = 0;
    model_reset();
    chk_en = 1;
  endtask

  task automatic run_final();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    nfail++;
    $display("FAIL watchdog expired");
    run_final();
  end

  initial begin
    int edges;
    void'($urandom(32'd2718));
    model_reset();

    // R8 then R7: aligned edges with default ratios reach lock
    do_reset();
    repeat (8) step(1, 1, 0, 0, 0);
    check(locked == 0, "R7", "locked before threshold", int'(locked), 0);
    repeat (32) step(1, 1, 0, 0, 0);
    check(locked == 1, "R7", "locked after aligned run", int'(locked), 1);
    step(1, 1, 1, 2'd1, 16'd7);
    repeat (120) step(1, 1, 0, 0, 0);
    check(locked == 0, "R7", "locked after ratio mismatch", int'(locked), 0);

    // R7 with a programmed threshold of 8
    do_reset();
    step(0, 0, 1, 2'd3, 16'd8);
    repeat (27) step(1, 1, 0, 0, 0);
    check(locked == 0, "R7", "locked under threshold 8", int'(locked), 0);
    repeat (33) step(1, 1, 0, 0, 0);
    check(locked == 1, "R7", "locked at threshold 8", int'(locked), 1);

    // R3: ratio 0 behaves as 2
    do_reset();
    step(1, 0, 1, 2'd0, 16'd0);
    repeat (20) step(1, 0, 0, 0, 0);
    edges = 0;
    for (int k = 0; k < 20; k++) begin
      step(1, 0, 0, 0, 0);
      edges += int'(ref_edge);
    end
    check(edges == 10, "R3", "ref edges in 20 ticks at ratio 0", edges, 10);

    // R6 directed levels
    step(0, 0, 1, 2'd2, 16'd3);
    step(0, 0, 1, 2'd2, 16'hFFF1);
    step(0, 0, 0, 0, 0);
    check(pump_isel == 2'd1, "R6", "pump_isel after two writes", int'(pump_isel), 1);

    // Random strobes and rewrites (R1 R2 R3 R4 R5 R6)
    do_reset();
    for (int k = 0; k < 20000; k++) begin
      logic rt, ot, we;
      logic [1:0] a;
      logic [15:0] d;
      int r;
      rt = ($urandom % 3) != 0;
      ot = ($urandom % 2) != 0;
      we = ($urandom % 12) == 0;
      a  = 2'($urandom % 3);
      r  = int'($urandom % 8);
      d  = (r == 0) ? 16'd0 : (r == 1) ? 16'd1 : 16'(2 + $urandom % 10);
      step(rt, ot, we, a, d);
    end
    step(0, 0, 0, 0, 0);
    run_final();
  end
endmodule